// File: doc/BRIEF.md
# Word Multiply-Accumulate Execution Unit

This block is an execution unit for 32-bit integer multiply operations. An issue stage presents a 4-bit operation select, two source words, two accumulator words, a rounding bit and a flag-update bit, and pulses `start`. One clock later the unit returns one or two result words, the negative and zero condition flags, and a strobe that tells the writeback stage whether the flags are to be written.

The operations fall into four groups. The first is a multiply and a multiply-add that keep only the low word. The second is signed and unsigned 32x32 to 64-bit multiplies, each with or without a 64-bit accumulate. The third is an unsigned multiply that adds two separate 32-bit addends. The fourth is signed high-word multiply, multiply-add and multiply-subtract, each with optional rounding. Register reads and writes, condition evaluation and operand legality checks belong to the surrounding pipeline and are not done here.

Top module: `mac_word_unit`

## Requirements
- R1: Code 0 returns the low 32 bits of srcN*srcM on resLo. Code 1 returns the low 32 bits of srcN*srcM+accLo. In both cases resHi is 0.
- R2: For codes 0 and 1 with flagEn=1, flagWr is 1, flagN is bit 31 of resLo, and flagZ is 1 exactly when resLo is 0.
- R3: Code 2 zero-extends both sources and returns the 64-bit product as {resHi,resLo}. Code 3 does the same and adds {accHi,accLo}.
- R4: Code 4 sign-extends both sources and returns the 64-bit signed product as {resHi,resLo}. Code 5 does the same and adds {accHi,accLo}.
- R5: For codes 2 to 5 with flagEn=1, flagWr is 1, flagN is bit 63 of the 64-bit result, and flagZ is 1 only when all 64 bits are zero.
- R6: Code 6 returns the unsigned srcN*srcM + accLo + accHi as a 64-bit value on {resHi,resLo}, with both addends zero-extended. It never raises flagWr, flagN or flagZ.
- R7: Codes 7, 8 and 9 form a 64-bit value with accLo in bits 63:32 and zeros below. Code 7 uses zero as the accumulator. Codes 7 and 8 add the signed product to this value and code 9 subtracts the product from it. Bits 63:32 of the result go on resLo, and resHi is 0.
- R8: For codes 7 to 9 with roundEn=1, the result is incremented by 1 when bit 31 of the 64-bit intermediate is 1.
- R9: Codes 7 to 9 never raise flagWr, flagN or flagZ.
- R10: Codes 10 to 15 give all-zero results and flags, and resultValid stays 0. doneOut still pulses.
- R11: Results, flags, doneOut and resultValid appear on the clock edge after the edge that samples start=1. doneOut and resultValid are one-cycle pulses. Results hold their value while start is 0.
- R12: While rst_n is 0, all outputs are 0.
- R13: With flagEn=0, flagWr, flagN and flagZ are 0 for every code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Issue strobe, one cycle per operation |
| opSel | input | 4 | Operation select (codes 0 to 9 are legal) |
| srcN | input | 32 | First source word |
| srcM | input | 32 | Second source word |
| accLo | input | 32 | Accumulator low word, or the single accumulator word |
| accHi | input | 32 | Accumulator high word, or the second addend |
| roundEn | input | 1 | Round the high-word result |
| flagEn | input | 1 | Request an N/Z flag update |
| resLo | output | 32 | Low result word |
| resHi | output | 32 | High result word |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagWr | output | 1 | Flags are to be written |
| doneOut | output | 1 | Pulse one cycle after every start |
| resultValid | output | 1 | Pulse with doneOut when the code was legal |

## Verification
Every result, flag and strobe is registered once, so it is due on the edge that follows the edge that sampled start. The bench raises start on a falling edge and lowers it on the next falling edge, and it reads all outputs at that point, half a cycle after the capturing edge. One extra falling edge later it checks that doneOut has dropped and that the results have held while start is low. The checker also ties each start to a done pulse exactly one edge later.

// File: rtl/mac_pkg.sv
package mac_pkg;

  typedef enum logic [3:0] {
    OP_MUL   = 4'd0,
    OP_MLA   = 4'd1,
    OP_UMULL = 4'd2,
    OP_UMLAL = 4'd3,
    OP_SMULL = 4'd4,
    OP_SMLAL = 4'd5,
    OP_UDUAL = 4'd6,
    OP_HMUL  = 4'd7,
    OP_HMLA  = 4'd8,
    OP_HMLS  = 4'd9
  } op_e;

  typedef enum logic [2:0] {
    ACC_NONE = 3'd0,
    ACC_LO   = 3'd1,
    ACC_WIDE = 3'd2,
    ACC_DUAL = 3'd3,
    ACC_HIGH = 3'd4
  } acc_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic legal;
    logic signedSrc;
    acc_e accSel;
    logic subtract;
    logic highWord;
    logic wideRes;
    logic flagCap;
  } ctrl_t;

endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] opSel,
  output ctrl_t      ctrl,
  output logic       doneQ,
  output logic       validQ
);

  always_comb begin
    ctrl = '0;
    ctrl.capture = start;
    ctrl.accSel  = ACC_NONE;
    case (opSel)
      OP_MUL:   begin ctrl.legal = 1'b1; ctrl.flagCap = 1'b1; end
      OP_MLA:   begin ctrl.legal = 1'b1; ctrl.flagCap = 1'b1; ctrl.accSel = ACC_LO; end
      OP_UMULL: begin ctrl.legal = 1'b1; ctrl.flagCap = 1'b1; ctrl.wideRes = 1'b1; end
      OP_UMLAL: begin
        ctrl.legal = 1'b1; ctrl.flagCap = 1'b1; ctrl.wideRes = 1'b1; ctrl.accSel = ACC_WIDE;
      end
      OP_SMULL: begin
        ctrl.legal = 1'b1; ctrl.flagCap = 1'b1; ctrl.wideRes = 1'b1; ctrl.signedSrc = 1'b1;
      end
      OP_SMLAL: begin
        ctrl.legal = 1'b1; ctrl.flagCap = 1'b1; ctrl.wideRes = 1'b1; ctrl.signedSrc = 1'b1;
        ctrl.accSel = ACC_WIDE;
      end
      OP_UDUAL: begin ctrl.legal = 1'b1; ctrl.wideRes = 1'b1; ctrl.accSel = ACC_DUAL; end
      OP_HMUL:  begin ctrl.legal = 1'b1; ctrl.signedSrc = 1'b1; ctrl.highWord = 1'b1; end
      OP_HMLA:  begin
        ctrl.legal = 1'b1; ctrl.signedSrc = 1'b1; ctrl.highWord = 1'b1; ctrl.accSel = ACC_HIGH;
      end
      OP_HMLS:  begin
        ctrl.legal = 1'b1; ctrl.signedSrc = 1'b1; ctrl.highWord = 1'b1; ctrl.accSel = ACC_HIGH;
        ctrl.subtract = 1'b1;
      end
      default:  ctrl.legal = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      doneQ  <= 1'b0;
      validQ <= 1'b0;
    end else begin
      doneQ  <= start;
      validQ <= start & ctrl.legal;
    end
  end

endmodule

// File: rtl/mac_dp.sv
module mac_dp
  import mac_pkg::*;
#(
  parameter int WORD = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ctrl_t           ctrl,
  input  logic [WORD-1:0] srcN,
  input  logic [WORD-1:0] srcM,
  input  logic [WORD-1:0] accLo,
  input  logic [WORD-1:0] accHi,
  input  logic            roundEn,
  input  logic            flagEn,
  output logic [WORD-1:0] resLoQ,
  output logic [WORD-1:0] resHiQ,
  output logic            flagNQ,
  output logic            flagZQ,
  output logic            flagWrQ
);

  localparam int DBL = 2 * WORD;

  logic [DBL-1:0]  nExt, mExt, prod, addend, sum;
  logic [WORD-1:0] highW, loNext, hiNext;
  logic            nNext, zNext, wrNext;

  always_comb begin
    nExt = ctrl.signedSrc ? {{WORD{srcN[WORD-1]}}, srcN} : {{WORD{1'b0}}, srcN};
    mExt = ctrl.signedSrc ? {{WORD{srcM[WORD-1]}}, srcM} : {{WORD{1'b0}}, srcM};
    prod = nExt * mExt;
  end

  always_comb begin
    case (ctrl.accSel)
      ACC_LO:   addend = {{WORD{1'b0}}, accLo};
      ACC_WIDE: addend = {accHi, accLo};
      ACC_DUAL: addend = {{WORD{1'b0}}, accLo} + {{WORD{1'b0}}, accHi};
      ACC_HIGH: addend = {accLo, {WORD{1'b0}}};
      default:  addend = '0;
    endcase
    sum   = ctrl.subtract ? (addend - prod) : (addend + prod);
    highW = sum[DBL-1:WORD] + WORD'(roundEn & sum[WORD-1]);
  end

  always_comb begin
    loNext = '0;
    hiNext = '0;
    if (ctrl.legal) begin
      if (ctrl.highWord) begin
        loNext = highW;
      end else begin
        loNext = sum[WORD-1:0];
        hiNext = ctrl.wideRes ? sum[DBL-1:WORD] : '0;
      end
    end
    wrNext = ctrl.legal & ctrl.flagCap & flagEn;
    nNext  = wrNext & (ctrl.wideRes ? sum[DBL-1] : sum[WORD-1]);
    zNext  = wrNext & (ctrl.wideRes ? (sum == '0) : (sum[WORD-1:0] == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resLoQ  <= '0;
      resHiQ  <= '0;
      flagNQ  <= 1'b0;
      flagZQ  <= 1'b0;
      flagWrQ <= 1'b0;
    end else if (ctrl.capture) begin
      resLoQ  <= loNext;
      resHiQ  <= hiNext;
      flagNQ  <= nNext;
      flagZQ  <= zNext;
      flagWrQ <= wrNext;
    end else begin
      flagWrQ <= 1'b0;
    end
  end

endmodule

// File: rtl/mac_word_unit.sv
module mac_word_unit
  import mac_pkg::*;
#(
  parameter int WORD = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [3:0]      opSel,
  input  logic [WORD-1:0] srcN,
  input  logic [WORD-1:0] srcM,
  input  logic [WORD-1:0] accLo,
  input  logic [WORD-1:0] accHi,
  input  logic            roundEn,
  input  logic            flagEn,
  output logic [WORD-1:0] resLo,
  output logic [WORD-1:0] resHi,
  output logic            flagN,
  output logic            flagZ,
  output logic            flagWr,
  output logic            doneOut,
  output logic            resultValid
);

  ctrl_t ctrl;

  mac_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .opSel  (opSel),
    .ctrl   (ctrl),
    .doneQ  (doneOut),
    .validQ (resultValid)
  );

  mac_dp #(.WORD(WORD)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl    (ctrl),
    .srcN    (srcN),
    .srcM    (srcM),
    .accLo   (accLo),
    .accHi   (accHi),
    .roundEn (roundEn),
    .flagEn  (flagEn),
    .resLoQ  (resLo),
    .resHiQ  (resHi),
    .flagNQ  (flagN),
    .flagZQ  (flagZ),
    .flagWrQ (flagWr)
  );

endmodule

// File: rtl/mac_word_chk.sv
module mac_word_chk #(
  parameter int WORD = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [3:0]      opSel,
  input logic            flagEn,
  input logic [WORD-1:0] resLo,
  input logic [WORD-1:0] resHi,
  input logic            flagN,
  input logic            flagZ,
  input logic            flagWr,
  input logic            doneOut,
  input logic            resultValid
);

  a_r11_done_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> doneOut);

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !doneOut);

  a_r11_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(resLo) && $stable(resHi)));

  a_r11_valid_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |-> doneOut);

  a_r10_unused_code: assert property (@(posedge clk) disable iff (!rst_n)
    (start && opSel > 4'd9) |=> (!resultValid && resLo == '0 && resHi == '0 && !flagWr));

  a_r9_high_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (start && opSel >= 4'd7 && opSel <= 4'd9) |=> (!flagWr && !flagN && !flagZ));

  a_r6_dual_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (start && opSel == 4'd6) |=> (!flagWr && !flagN && !flagZ));

  a_r13_flag_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !flagEn) |=> (!flagWr && !flagN && !flagZ));

  a_r1_mul_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (start && opSel <= 4'd1) |=> (resHi == '0));

endmodule

bind mac_word_unit mac_word_chk #(.WORD(WORD)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .opSel       (opSel),
  .flagEn      (flagEn),
  .resLo       (resLo),
  .resHi       (resHi),
  .flagN       (flagN),
  .flagZ       (flagZ),
  .flagWr      (flagWr),
  .doneOut     (doneOut),
  .resultValid (resultValid)
);

// File: tb/sim_mac_word_unit.sv
module sim_mac_word_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  opSel = '0;
  logic [31:0] srcN = '0, srcM = '0, accLo = '0, accHi = '0;
  logic        roundEn = 1'b0, flagEn = 1'b0;
  logic [31:0] resLo, resHi;
  logic        flagN, flagZ, flagWr, doneOut, resultValid;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mac_word_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .opSel(opSel),
    .srcN(srcN), .srcM(srcM), .accLo(accLo), .accHi(accHi),
    .roundEn(roundEn), .flagEn(flagEn),
    .resLo(resLo), .resHi(resHi), .flagN(flagN), .flagZ(flagZ),
    .flagWr(flagWr), .doneOut(doneOut), .resultValid(resultValid)
  );

  // op, n, m, accLo, accHi, round, flagEn
  localparam int VW = 4 + 32*4 + 2;
  localparam int NV = 14;
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd0, 32'h0001_2345, 32'h0000_0100, 32'h0, 32'h0, 1'b0, 1'b1},
    {4'd1, 32'hFFFF_FFFF, 32'h0000_0003, 32'h0000_0010, 32'h0, 1'b0, 1'b1},
    {4'd2, 32'h8000_0001, 32'h7FFF_FFFF, 32'h0, 32'h0, 1'b0, 1'b1},
    {4'd3, 32'h1234_5678, 32'h9ABC_DEF0, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b1},
    {4'd4, 32'h8000_0000, 32'h0000_0002, 32'h0, 32'h0, 1'b0, 1'b1},
    {4'd5, 32'hFFFF_FFFE, 32'h0000_0005, 32'h0000_000A, 32'h0, 1'b0, 1'b1},
    {4'd6, 32'hDEAD_BEEF, 32'h0BAD_F00D, 32'hFFFF_0000, 32'h1234_5678, 1'b0, 1'b1},
    {4'd7, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h0, 32'h0, 1'b0, 1'b1},
    {4'd7, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h0, 32'h0, 1'b1, 1'b1},
    {4'd8, 32'hC000_0000, 32'h0003_0001, 32'h0000_1000, 32'h0, 1'b1, 1'b0},
    {4'd9, 32'h0123_4567, 32'hFEDC_BA98, 32'h8000_0000, 32'h0, 1'b0, 1'b1},
    {4'd9, 32'h0123_4567, 32'hFEDC_BA98, 32'h8000_0000, 32'h0, 1'b1, 1'b1},
    {4'd0, 32'h0001_0000, 32'h0001_0000, 32'h0, 32'h0, 1'b0, 1'b1},
    {4'd4, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0, 32'h0, 1'b0, 1'b0}
  };

  // Expected results from the requirement text
  task automatic model(input logic [3:0] op, input logic [31:0] n, m, lo, hi,
                       input logic rnd, flg,
                       output logic [31:0] eLo, eHi, output logic eV, eWr, eN, eZ);
    logic [63:0] s, su, acc;
    logic [31:0] w;
    su = {32'h0, n} * {32'h0, m};
    s  = 64'(longint'($signed(n)) * longint'($signed(m)));
    eLo = '0; eHi = '0; eV = 1'b1; eWr = 1'b0; eN = 1'b0; eZ = 1'b0;
    case (op)
      4'd0, 4'd1: begin // R1 R2
        eLo = n * m + ((op == 4'd1) ? lo : 32'h0);
        eWr = flg; eN = flg & eLo[31]; eZ = flg & (eLo == 0);
      end
      4'd2, 4'd3, 4'd4, 4'd5: begin // R3 R4 R5
        acc = (op == 4'd3 || op == 4'd5) ? {hi, lo} : 64'h0;
        acc = acc + ((op >= 4'd4) ? s : su);
        {eHi, eLo} = acc;
        eWr = flg; eN = flg & acc[63]; eZ = flg & (acc == 0);
      end
      4'd6: {eHi, eLo} = su + {32'h0, lo} + {32'h0, hi}; // R6
      4'd7, 4'd8, 4'd9: begin // R7 R8
        acc = (op == 4'd7) ? 64'h0 : {lo, 32'h0};
        acc = (op == 4'd9) ? acc - s : acc + s;
        w = acc[63:32];
        if (rnd && acc[31]) w = w + 1;
        eLo = w;
      end
      default: eV = 1'b0; // R10
    endcase
  endtask

  task automatic chk(input string req, input string what, input logic [63:0] got, exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [31:0] n, m, lo, hi,
                       input logic rnd, flg);
    @(negedge clk);
    opSel = op; srcN = n; srcM = m; accLo = lo; accHi = hi; roundEn = rnd; flagEn = flg;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] eLo, eHi;
    logic eV, eWr, eN, eZ;
    string tag;

    // R12 reset state
    repeat (2) @(negedge clk);
    chk("R12", "outputs in reset",
        {resLo, resHi}, 64'h0);
    chk("R12", "strobes in reset",
        {59'h0, flagN, flagZ, flagWr, doneOut, resultValid}, 64'h0);
    rst_n = 1'b1;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      issue(v[133:130], v[129:98], v[97:66], v[65:34], v[33:2], v[1], v[0]);
      model(v[133:130], v[129:98], v[97:66], v[65:34], v[33:2], v[1], v[0],
            eLo, eHi, eV, eWr, eN, eZ);
      case (v[133:130])
        4'd0, 4'd1: tag = "R1/R2";
        4'd2, 4'd3: tag = "R3/R5";
        4'd4, 4'd5: tag = "R4/R5";
        4'd6:       tag = "R6";
        default:    tag = "R7/R8/R9";
      endcase
      chk(tag, "result", {resHi, resLo}, {eHi, eLo});
      chk(tag, "flags", {60'h0, flagWr, flagN, flagZ, resultValid}, {60'h0, eWr, eN, eZ, eV});
    end

    // R3 unsigned max operands
    issue(4'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 1);
    chk("R3", "umul max", {resHi, resLo}, 64'hFFFF_FFFE_0000_0001);
    // R4 signed -1 * -1
    issue(4'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 1);
    chk("R4", "smul -1*-1", {resHi, resLo}, 64'h1);
    // R5 low word zero but high word not: Z stays 0
    issue(4'd2, 32'h0001_0000, 32'h0001_0000, 0, 0, 0, 1);
    chk("R5", "Z needs 64 zero bits", {62'h0, flagZ, flagN}, 64'h0);
    chk("R5", "2^32 result", {resHi, resLo}, 64'h1_0000_0000);
    // R2 N from bit 31
    issue(4'd0, 32'h8000_0000, 32'h1, 0, 0, 0, 1);
    chk("R2", "N set", {62'h0, flagWr, flagN}, 64'h3);
    // R6 sum wraps to all ones, flags not raised
    issue(4'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1);
    chk("R6", "dual addend", {resHi, resLo}, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R6", "no flags", {61'h0, flagWr, flagN, flagZ}, 64'h0);
    // R8 rounding on bit 31
    issue(4'd7, 32'h4000_0000, 32'h2, 0, 0, 0, 1);
    chk("R8", "unrounded", {resHi, resLo}, 64'h0);
    issue(4'd7, 32'h4000_0000, 32'h2, 0, 0, 1, 1);
    chk("R8", "rounded", {resHi, resLo}, 64'h1);
    // R7 subtract crossing the word boundary
    issue(4'd9, 32'h1, 32'h1, 32'h1, 0, 0, 1);
    chk("R7", "sub high", {resHi, resLo}, 64'h0);
    issue(4'd9, 32'h1, 32'h1, 32'h1, 0, 1, 1);
    chk("R8", "sub rounded", {resHi, resLo}, 64'h1);
    chk("R9", "no flags", {61'h0, flagWr, flagN, flagZ}, 64'h0);
    // R13 flag gate with a zero result
    issue(4'd0, 32'h0, 32'h5, 0, 0, 0, 0);
    chk("R13", "flags gated", {61'h0, flagWr, flagN, flagZ}, 64'h0);
    // R10 unused code
    issue(4'd5, 32'h3, 32'h3, 0, 0, 0, 1);
    issue(4'd12, 32'h3, 32'h3, 32'h7, 32'h7, 0, 1);
    chk("R10", "zero results", {resHi, resLo}, 64'h0);
    chk("R10", "strobes", {61'h0, doneOut, resultValid, flagWr}, 64'h4);
    // R11 pulse width and hold
    issue(4'd1, 32'h3, 32'h4, 32'h5, 0, 0, 1);
    chk("R11", "due one cycle later", {31'h0, doneOut, resultValid, resLo}, {31'h0, 1'b1, 1'b1, 32'd17});
    opSel = 4'd2; srcN = 32'hFFFF; srcM = 32'hFFFF;
    @(negedge clk);
    chk("R11", "done drops", {62'h0, doneOut, resultValid}, 64'h0);
    chk("R11", "result held", {resHi, resLo}, 64'd17);

    finish_run();
  end

endmodule